// File: doc/BRIEF.md
# Cycle-Stealing Memory-to-Device Transfer Channel

This block moves a block of words from memory to an output device without
the processor running any instructions for it. Software loads a start
address and a word count. The channel then reads one word at a time
through the single memory port that it shares with the processor. Each
read takes one memory cycle away from the processor, and the processor
stalls for that cycle only. The words pass through a small FIFO to a
valid/ready stream that feeds the device. When the last word of the block
has been read, the channel raises an interrupt line. The line stays high
until software gives the channel new work or acknowledges it.

The memory port returns read data combinationally, in the same cycle as
the address. An arbiter decides who owns each memory cycle. The channel
wins a contested cycle, except that it never takes two contested cycles
in a row: a waiting processor always gets the cycle after a stolen one.
The device stream follows the usual rules. A word is transferred on a
clock edge where `dev_valid` and `dev_ready` are both high. Once
`dev_valid` is raised, it stays high with `dev_data` unchanged until the
word is accepted. While the device holds `dev_ready` low, the FIFO fills,
and the channel then stops requesting memory cycles, so back-pressure
reaches all the way to the arbiter. The address and count widths must not
exceed the configuration data width.

Top module: `dma_steal_chan`

## Requirements
- R1: Reset clears the state. The count is zero, `irq` is low, `dev_valid` is low, `dma_act` is low, and no memory cycle is taken by the channel.
- R2: In any cycle where the channel takes no memory cycle, a processor request is granted in the same cycle (`cpu_gnt` = `cpu_req`), and `mem_addr` equals `cpu_addr`.
- R3: In a cycle that the channel takes (`dma_act` high), `cpu_gnt` is low and the channel's address is on `mem_addr`. When both sides want a cycle and the previous cycle was not stolen, the channel wins.
- R4: If the previous cycle was taken by the channel and the processor requests now, the processor gets this cycle.
- R5: `cfg_sel` = 0 writes the start address. The n-th word read since that write (counting from zero) is read from start+n, modulo 2^AW.
- R6: `cfg_sel` = 1 writes the word count N. Exactly N memory cycles are then taken, and none after the count reaches zero.
- R7: `irq` rises on the clock edge of the last read of a block and stays high until a write to the count (`cfg_sel` = 1) or a write to the acknowledge register (`cfg_sel` = 2). Either write clears it.
- R8: Words appear on `dev_data` in read order, each equal to the memory data of its address. `dev_data` is held stable while `dev_valid` is high and `dev_ready` is low.
- R9: With `dev_ready` held low, the channel takes at most DEPTH cycles and then leaves every memory cycle to the processor.
- R10: The channel takes no memory cycle in any cycle where `cfg_we` is high.
- R11: Writing a count of zero stops the channel. Words already buffered are still delivered, no further cycles are taken, and `irq` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 address, 1 count, 2 interrupt acknowledge |
| cfg_wdata | input | DW | Configuration write data |
| irq | output | 1 | Block-complete interrupt |
| cpu_req | input | 1 | Processor wants the memory cycle |
| cpu_addr | input | AW | Processor address |
| cpu_gnt | output | 1 | Processor owns this memory cycle |
| mem_en | output | 1 | Memory cycle active |
| mem_addr | output | AW | Memory address |
| mem_rdata | input | DW | Memory read data, valid in the same cycle |
| dma_act | output | 1 | This memory cycle is taken by the channel |
| dev_valid | output | 1 | Device stream word valid |
| dev_ready | input | 1 | Device accepts the word |
| dev_data | output | DW | Device stream word |

## Verification
A wrong address or count register shows up on `mem_addr` in the very next
stolen cycle. It shows up again at the end of the block, as one read too
many or too few and a misplaced `irq` edge. A broken arbiter history bit
shows up the first time the processor and the channel contend for two
cycles in a row: `dma_act` stays high, or `cpu_gnt` is missing, in that
same cycle. A damaged FIFO pointer or occupancy value is seen on the
stream within DEPTH accepted words, either as out-of-order `dev_data` or
as extra reads while the device is stalled.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [1:0] {
    SEL_ADDR  = 2'd0,
    SEL_COUNT = 2'd1,
    SEL_ACK   = 2'd2
  } cfg_sel_e;
endpackage

// File: rtl/dma_xfer_regs.sv
module dma_xfer_regs
  import dma_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  cfg_sel_e      cfg_sel,
  input  logic [DW-1:0] cfg_wdata,
  input  logic          step,
  output logic [AW-1:0] addr,
  output logic          active,
  output logic          irq
);
  logic [CW-1:0] cnt;

  assign active = (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr <= '0;
      cnt  <= '0;
      irq  <= 1'b0;
    end else if (cfg_we) begin
      case (cfg_sel)
        SEL_ADDR:  addr <= cfg_wdata[AW-1:0];
        SEL_COUNT: begin
          cnt <= cfg_wdata[CW-1:0];
          irq <= 1'b0;
        end
        SEL_ACK:   irq <= 1'b0;
        default:   ;
      endcase
    end else if (step) begin
      addr <= addr + AW'(1);
      cnt  <= cnt - CW'(1);
      if (cnt == CW'(1)) irq <= 1'b1;
    end
  end

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> addr == $past(addr) + AW'(1)); // R5
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> cnt == $past(cnt) - CW'(1)); // R6
  AST_STEP_NEEDS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> cnt != '0); // R6
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(cfg_we && (cfg_sel == SEL_COUNT || cfg_sel == SEL_ACK))) |=> irq); // R7
endmodule

// File: rtl/dma_arb.sv
module dma_arb (
  input  logic clk,
  input  logic rst_n,
  input  logic cpu_req,
  input  logic dma_req,
  output logic cpu_gnt,
  output logic dma_gnt
);
  logic stole_last;

  assign dma_gnt = dma_req && !(stole_last && cpu_req);
  assign cpu_gnt = cpu_req && !dma_gnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stole_last <= 1'b0;
    else        stole_last <= dma_gnt;
  end
endmodule

// File: rtl/dma_fifo.sv
module dma_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] din,
  output logic          full,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] dout
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int UW = $clog2(DEPTH + 1);

  logic [DW-1:0] store [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [UW-1:0] used;
  logic          pop;

  assign out_valid = (used != '0);
  assign full      = (used == UW'(DEPTH));
  assign pop       = out_valid && out_ready;
  assign dout      = store[rp];

  always_ff @(posedge clk) begin
    if (push) store[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp   <= '0;
      rp   <= '0;
      used <= '0;
    end else begin
      if (push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + PW'(1);
      if (pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + PW'(1);
      case ({push, pop})
        2'b10:   used <= used + UW'(1);
        2'b01:   used <= used - UW'(1);
        default: used <= used;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !push); // R9
  AST_STREAM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(dout))); // R8
endmodule

// File: rtl/dma_steal_chan.sv
module dma_steal_chan
  import dma_pkg::*;
#(
  parameter int AW    = 16,
  parameter int CW    = 16,
  parameter int DW    = 16,
  parameter int DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [DW-1:0] cfg_wdata,
  output logic          irq,
  input  logic          cpu_req,
  input  logic [AW-1:0] cpu_addr,
  output logic          cpu_gnt,
  output logic          mem_en,
  output logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_rdata,
  output logic          dma_act,
  output logic          dev_valid,
  input  logic          dev_ready,
  output logic [DW-1:0] dev_data
);
  logic [AW-1:0] ch_addr;
  logic          ch_active;
  logic          fifo_full;
  logic          dma_req;
  logic          dma_gnt;

  assign dma_req  = ch_active && !fifo_full && !cfg_we;
  assign dma_act  = dma_gnt;
  assign mem_en   = dma_gnt || cpu_gnt;
  assign mem_addr = dma_gnt ? ch_addr : cpu_addr;

  dma_xfer_regs #(.AW(AW), .CW(CW), .DW(DW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel_e'(cfg_sel)),
    .cfg_wdata (cfg_wdata),
    .step      (dma_gnt),
    .addr      (ch_addr),
    .active    (ch_active),
    .irq       (irq)
  );

  dma_arb u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .cpu_req (cpu_req),
    .dma_req (dma_req),
    .cpu_gnt (cpu_gnt),
    .dma_gnt (dma_gnt)
  );

  dma_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (dma_gnt),
    .din       (mem_rdata),
    .full      (fifo_full),
    .out_valid (dev_valid),
    .out_ready (dev_ready),
    .dout      (dev_data)
  );

  AST_CPU_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && $past(dma_gnt)) |-> (cpu_gnt && !dma_gnt)); // R4
  AST_CFG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |-> !dma_act); // R10
  AST_IDLE_NO_STEAL: assert property (@(posedge clk) disable iff (!rst_n)
    !ch_active |-> !dma_act); // R6
endmodule

// File: tb/tb_dma_steal_chan.sv
`timescale 1ns/100ps
module tb_dma_steal_chan;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam logic [15:0] KEY = 16'h5A3C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sel = 2'd0;
  logic [DW-1:0] cfg_wdata = '0;
  logic irq, cpu_gnt, mem_en, dma_act, dev_valid;
  logic cpu_req = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_rdata, dev_data;
  logic dev_ready = 1'b0;

  always #2.5 clk = ~clk;
  assign mem_rdata = mem_addr ^ KEY;

  dma_steal_chan dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .irq(irq), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
    .cpu_gnt(cpu_gnt), .mem_en(mem_en), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .dma_act(dma_act), .dev_valid(dev_valid),
    .dev_ready(dev_ready), .dev_data(dev_data)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic cr, input logic rdy);
    @(negedge clk);
    cfg_we = 1'b0;
    cpu_req = cr;
    dev_ready = rdy;
    #1;
  endtask

  task automatic cfg(input logic [1:0] sel, input logic [15:0] val);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_sel = sel;
    cfg_wdata = val;
    cpu_req = 1'b0;
    #1;
    chk(!dma_act, "R10", int'(dma_act), 0);
  endtask

  // start address, count, processor request pattern, device ready pattern
  localparam logic [47:0] VEC [5] = '{
    {16'h0010, 8'd6,  8'h00, 8'hFF},
    {16'h1234, 8'd9,  8'hFF, 8'hFF},
    {16'hFFFE, 8'd5,  8'hA6, 8'hD7},
    {16'h0400, 8'd1,  8'hFF, 8'h01},
    {16'h0800, 8'd12, 8'h63, 8'h9B}
  };

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 100000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R1 reset state, R2 processor ownership while idle
    cpu_req = 1'b1;
    cpu_addr = 16'h0ABC;
    repeat (3) @(negedge clk);
    #1;
    chk(irq == 1'b0, "R1", int'(irq), 0);
    chk(dev_valid == 1'b0, "R1", int'(dev_valid), 0);
    chk(dma_act == 1'b0, "R1", int'(dma_act), 0);
    chk(cpu_gnt && mem_addr == 16'h0ABC, "R2", int'(mem_addr), 16'h0ABC);
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b0, 1'b1);
    chk(!dma_act && !dev_valid, "R1", int'(dma_act), 0);

    // table walk
    foreach (VEC[v]) begin
      logic [15:0] a0;
      logic [7:0]  n, cp, rp;
      logic [15:0] exp_a;
      int rcv, ndma, cyc;
      logic prev;
      {a0, n, cp, rp} = VEC[v];
      cfg(2'd0, a0);
      cfg(2'd1, {8'h00, n});
      exp_a = a0; rcv = 0; ndma = 0; cyc = 0; prev = 1'b0;
      while (rcv < int'(n) && cyc < 300) begin
        @(negedge clk);
        cfg_we = 1'b0;
        cpu_req = cp[cyc % 8];
        dev_ready = rp[cyc % 8];
        cpu_addr = 16'h0F00 + 16'(cyc);
        #1;
        if (cyc == 0) chk(irq == 1'b0, "R7", int'(irq), 0);
        if (dma_act) begin
          chk(mem_addr == exp_a, "R5", int'(mem_addr), int'(exp_a));
          chk(!cpu_gnt, "R3", int'(cpu_gnt), 0);
          exp_a = exp_a + 16'd1;
          ndma++;
        end else if (cpu_req) begin
          chk(cpu_gnt && mem_addr == cpu_addr, "R2", int'(mem_addr), int'(cpu_addr));
        end
        if (cpu_req && prev) chk(!dma_act && cpu_gnt, "R4", int'(dma_act), 0);
        if (dev_valid && dev_ready) begin
          chk(dev_data == ((a0 + 16'(rcv)) ^ KEY), "R8", int'(dev_data),
              int'((a0 + 16'(rcv)) ^ KEY));
          rcv++;
        end
        prev = dma_act;
        cyc++;
      end
      chk(ndma == int'(n), "R6", ndma, int'(n));
      for (int k = 0; k < 4; k++) begin
        step(1'b1, 1'b1);
        chk(!dma_act, "R6", int'(dma_act), 0);
        chk(irq == 1'b1, "R7", int'(irq), 1);
      end
    end

    // R7 acknowledge clears the interrupt
    cfg(2'd2, 16'h0000);
    step(1'b0, 1'b1);
    chk(irq == 1'b0, "R7", int'(irq), 0);

    // R3 / R4 contention with a processor that always requests
    cfg(2'd0, 16'h0100);
    cfg(2'd1, 16'd3);
    for (int k = 0; k < 7; k++) begin
      logic e;
      e = (k == 0 || k == 2 || k == 4);
      step(1'b1, 1'b1);
      chk(dma_act == e, "R3", int'(dma_act), int'(e));
      chk(cpu_gnt == !e, "R4", int'(cpu_gnt), int'(!e));
    end
    cfg(2'd2, 16'h0000);

    // R9 stalled device: only DEPTH steals, stable head word
    begin
      int nd;
      nd = 0;
      cfg(2'd0, 16'h0200);
      cfg(2'd1, 16'd5);
      for (int k = 0; k < 6; k++) begin
        step(1'b1, 1'b0);
        if (dma_act) nd++;
        if (k > 2) chk(cpu_gnt, "R9", int'(cpu_gnt), 1);
      end
      chk(nd == 2, "R9", nd, 2);
      chk(dev_valid && dev_data == (16'h0200 ^ KEY), "R8", int'(dev_data),
          int'(16'h0200 ^ KEY));
    end

    // R11 zero count stops the channel, buffered words still drain
    begin
      int got, nd;
      got = 0; nd = 0;
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = 2'd1; cfg_wdata = 16'd0; dev_ready = 1'b0;
      #1;
      for (int k = 0; k < 6; k++) begin
        step(1'b0, 1'b1);
        if (dma_act) nd++;
        if (dev_valid) begin
          chk(dev_data == ((16'h0200 + 16'(got)) ^ KEY), "R11", int'(dev_data),
              int'((16'h0200 + 16'(got)) ^ KEY));
          got++;
        end
      end
      chk(got == 2, "R11", got, 2);
      chk(nd == 0, "R11", nd, 0);
      chk(irq == 1'b0, "R11", int'(irq), 0);
    end

    // R10 configuration write in the middle of a block
    begin
      int nd;
      nd = 0;
      cfg(2'd0, 16'h0300);
      cfg(2'd1, 16'd4);
      step(1'b0, 1'b1);
      if (dma_act) nd++;
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = 2'd2; cfg_wdata = 16'd0;
      #1;
      chk(!dma_act, "R10", int'(dma_act), 0);
      for (int k = 0; k < 10; k++) begin
        step(1'b0, 1'b1);
        if (dma_act) nd++;
      end
      chk(nd == 4, "R10", nd, 4);
      chk(irq == 1'b1, "R7", int'(irq), 1);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule